// File: doc/BRIEF.md
# Zero-Cross Gated Stereo Volume and Mute

This block attenuates a stereo stream of signed PCM samples by one of 32 levels spaced 2 dB apart, from 0 dB to -62 dB, and mutes the stream on request. Left and right samples arrive together, marked by a valid strobe. Each accepted pair produces one scaled pair one clock later. A status flag reports whether either channel is currently muted. After reset the stage is muted and its outputs are zero.

When zero-cross gating is enabled, a change of mute state does not take effect at once. Each channel holds the change until its own signal crosses zero, which avoids an audible step. A typical source switch works as follows. Enable gating, request mute, and wait about one period of the path's low-frequency corner (roughly 50 ms for a 20 Hz corner). Then change the source upstream, release mute, and leave gating enabled. The stage then unmutes at the next crossing. A timeout counted in samples applies a pending change even when no crossing arrives, so a DC input cannot keep the stage stuck.

When gating is disabled, mute changes apply on the next accepted sample. Volume changes always apply on the next accepted sample.

Top module: `zc_volume`

## Requirements
- R1: After reset, muted_o is 1, left_o and right_o are 0 and valid_o is 0.
- R2: valid_o is high exactly one cycle after a cycle with valid_i high. Without valid_i, the outputs and the mute state hold, whatever the other inputs do.
- R3: Gain table: g(0)=32768, and g(k)=floor((g(k-1)*26029+16384)/32768) for k=1..31. An unmuted output equals floor((x*g(vol_i)+16384)/32768), so code 0 passes the sample through unchanged.
- R4: Code 31 is the quietest level (about -62 dB). Full-scale inputs of either sign never overflow at any code.
- R5: With zc_en_i low, each channel's mute state takes the value of mute_i on the same accepted sample.
- R6: With zc_en_i high, a release of mute is held and the output stays 0 until a sample on that channel is a zero crossing. A zero crossing is a sample equal to 0, or a sample whose sign bit differs from that of the previous accepted sample on that channel. The previous sample counts as 0 after reset. The change applies on the crossing sample itself.
- R7: The two channels gate independently. muted_o is 1 whenever either channel is muted.
- R8: A change held by gating is applied, at the latest, on the TIMEOUT-th consecutive accepted sample for which it is pending.
- R9: With zc_en_i high, a mute request is also held until a crossing or the timeout. Until then, the output keeps its scaled value at the current volume.
- R10: While a channel is muted, its output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample pair strobe |
| left_i | input | DATA_W | Left sample, signed |
| right_i | input | DATA_W | Right sample, signed |
| vol_i | input | VOL_W | Attenuation code, 0 = 0 dB, 31 = -62 dB |
| mute_i | input | 1 | Requested mute state |
| zc_en_i | input | 1 | Hold mute changes until a zero crossing |
| valid_o | output | 1 | Output pair strobe |
| left_o | output | DATA_W | Scaled left sample, signed |
| right_o | output | DATA_W | Scaled right sample, signed |
| muted_o | output | 1 | Either channel muted |

## Verification
The two functions that can fall on the same sample are the zero-crossing release and the timeout release. The bench runs a timeout of six samples. It holds a mute request pending on both channels for five samples. On the sixth, the left channel sees no crossing and the right channel presents a sign change. Both channels must switch exactly once on that sample, and the following ungated sample must show the expected state with no second toggle. Two other samples exercise coincidences as well. On one, a volume change lands during a pending gated change, and the output must be scaled at the new level. On another, both channels release in the same sample.

// File: rtl/zc_vol_pkg.sv
package zc_vol_pkg;
  localparam int GAIN_FRAC = 15;
  localparam int GAIN_W    = GAIN_FRAC + 1;
  localparam int STEP_NUM  = 26029;  // 10^(-0.1) in Q15

  function automatic int gain_at(input int k);
    int g;
    g = 1 << GAIN_FRAC;
    for (int i = 0; i < k; i++)
      g = (g * STEP_NUM + (1 << (GAIN_FRAC - 1))) >> GAIN_FRAC;
    return g;
  endfunction
endpackage

// File: rtl/zc_vol_gain.sv
module zc_vol_gain
  import zc_vol_pkg::*;
#(
  parameter int VOL_W = 5
) (
  input  logic [VOL_W-1:0]  vol_i,
  output logic [GAIN_W-1:0] gain_o
);
  localparam int NLEV = 1 << VOL_W;

  logic [GAIN_W-1:0] tbl [NLEV];

  for (genvar k = 0; k < NLEV; k++) begin : g_lvl
    assign tbl[k] = GAIN_W'(gain_at(k));
  end

  assign gain_o = tbl[vol_i];
endmodule

// File: rtl/zc_vol_chan.sv
module zc_vol_chan
  import zc_vol_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int TIMEOUT = 2400
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic                     mute_i,
  input  logic                     zc_en_i,
  input  logic [GAIN_W-1:0]        gain_i,
  input  logic signed [DATA_W-1:0] sample_i,
  output logic signed [DATA_W-1:0] sample_o,
  output logic                     muted_o
);
  localparam int CNT_W = $clog2(TIMEOUT + 1);
  localparam int PW    = DATA_W + GAIN_W + 1;
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (GAIN_FRAC - 1);

  logic              mute_q, mute_d, prev_neg_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              pending, zc_hit, timed, apply;
  logic signed [PW-1:0]     prod, rnd;
  logic signed [DATA_W-1:0] scaled, out_q;

  assign pending = mute_i != mute_q;
  assign zc_hit  = (sample_i == '0) || (sample_i[DATA_W-1] != prev_neg_q);
  assign timed   = cnt_q == CNT_W'(TIMEOUT - 1);
  assign apply   = !zc_en_i || zc_hit || timed;
  assign mute_d  = (pending && apply) ? mute_i : mute_q;

  assign prod   = PW'(sample_i) * $signed({1'b0, gain_i});
  assign rnd    = prod + HALF;
  assign scaled = DATA_W'(rnd >>> GAIN_FRAC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mute_q     <= 1'b1;
      prev_neg_q <= 1'b0;
      cnt_q      <= '0;
      out_q      <= '0;
    end else if (valid_i) begin
      mute_q     <= mute_d;
      prev_neg_q <= sample_i[DATA_W-1];
      cnt_q      <= (pending && !apply) ? cnt_q + 1'b1 : '0;
      out_q      <= mute_d ? '0 : scaled;
    end
  end

  assign sample_o = out_q;
  assign muted_o  = mute_q;

  AST_MUTED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mute_q |-> out_q == '0);  // R10
  AST_DIRECT_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !zc_en_i |=> mute_q == $past(mute_i));  // R5
  AST_GATE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && zc_en_i && !zc_hit && !timed |=> $stable(mute_q));  // R6
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(TIMEOUT));  // R8
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(out_q) && $stable(mute_q));  // R2
endmodule

// File: rtl/zc_volume.sv
module zc_volume
  import zc_vol_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int VOL_W   = 5,
  parameter int TIMEOUT = 2400
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [DATA_W-1:0] left_i,
  input  logic signed [DATA_W-1:0] right_i,
  input  logic [VOL_W-1:0]         vol_i,
  input  logic                     mute_i,
  input  logic                     zc_en_i,
  output logic                     valid_o,
  output logic signed [DATA_W-1:0] left_o,
  output logic signed [DATA_W-1:0] right_o,
  output logic                     muted_o
);
  localparam int NCH = 2;

  logic [GAIN_W-1:0]        gain;
  logic signed [DATA_W-1:0] in_s  [NCH];
  logic signed [DATA_W-1:0] out_s [NCH];
  logic [NCH-1:0]           ch_muted;
  logic                     valid_q;

  zc_vol_gain #(.VOL_W(VOL_W)) u_gain (
    .vol_i  (vol_i),
    .gain_o (gain)
  );

  assign in_s[0] = left_i;
  assign in_s[1] = right_i;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    zc_vol_chan #(.DATA_W(DATA_W), .TIMEOUT(TIMEOUT)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .valid_i  (valid_i),
      .mute_i   (mute_i),
      .zc_en_i  (zc_en_i),
      .gain_i   (gain),
      .sample_i (in_s[c]),
      .sample_o (out_s[c]),
      .muted_o  (ch_muted[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= valid_i;
  end

  assign valid_o = valid_q;
  assign left_o  = out_s[0];
  assign right_o = out_s[1];
  assign muted_o = |ch_muted;

  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);  // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);  // R2
  AST_FLAG_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    muted_o |-> (left_o == '0 || right_o == '0));  // R7
endmodule

// File: tb/sim_zc_volume.sv
module sim_zc_volume;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int TO = 6;

  typedef struct packed {
    logic [4:0] vol;
    logic       mute;
    logic       zc;
    logic signed [15:0] l;
    logic signed [15:0] r;
    logic       eml;
    logic       emr;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{5'd0,  1'b0, 1'b0,  16'sd1000,  -16'sd1000, 1'b0, 1'b0},
    '{5'd5,  1'b0, 1'b0,  16'sd20000, -16'sd12345, 1'b0, 1'b0},
    '{5'd31, 1'b0, 1'b0,  16'sd32767, -16'sd32768, 1'b0, 1'b0},
    '{5'd10, 1'b1, 1'b0,  16'sd500,    16'sd500,  1'b1, 1'b1},
    '{5'd10, 1'b0, 1'b1,  16'sd600,    16'sd700,  1'b1, 1'b1},
    '{5'd10, 1'b0, 1'b1, -16'sd50,     16'sd800,  1'b0, 1'b1},
    '{5'd10, 1'b0, 1'b1, -16'sd60,     16'sd0,    1'b0, 1'b0},
    '{5'd3,  1'b1, 1'b1, -16'sd70,     16'sd100,  1'b0, 1'b0},
    '{5'd3,  1'b1, 1'b1,  16'sd40,     16'sd200,  1'b1, 1'b0},
    '{5'd3,  1'b1, 1'b1,  16'sd50,    -16'sd5,    1'b1, 1'b1},
    '{5'd0,  1'b0, 1'b1,  16'sd100,    16'sd100,  1'b1, 1'b0},
    '{5'd0,  1'b0, 1'b1,  16'sd100,    16'sd100,  1'b1, 1'b0},
    '{5'd0,  1'b0, 1'b1,  16'sd100,    16'sd100,  1'b1, 1'b0},
    '{5'd0,  1'b0, 1'b1,  16'sd100,    16'sd100,  1'b1, 1'b0},
    '{5'd0,  1'b0, 1'b1,  16'sd100,    16'sd100,  1'b1, 1'b0},
    '{5'd0,  1'b0, 1'b1,  16'sd100,    16'sd100,  1'b0, 1'b0},
    '{5'd0,  1'b1, 1'b1,  16'sd100,    16'sd100,  1'b0, 1'b0},
    '{5'd0,  1'b1, 1'b1,  16'sd100,    16'sd100,  1'b0, 1'b0},
    '{5'd0,  1'b1, 1'b1,  16'sd100,    16'sd100,  1'b0, 1'b0},
    '{5'd0,  1'b1, 1'b1,  16'sd100,    16'sd100,  1'b0, 1'b0},
    '{5'd0,  1'b1, 1'b1,  16'sd100,    16'sd100,  1'b0, 1'b0},
    '{5'd0,  1'b1, 1'b1,  16'sd100,   -16'sd100,  1'b1, 1'b1},
    '{5'd2,  1'b0, 1'b0, -16'sd3,      16'sd3,    1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0;
  logic signed [DW-1:0] left = '0, right = '0;
  logic [4:0] vol = '0;
  logic mute = 1'b1, zc = 1'b0;
  logic valid_o, muted_o;
  logic signed [DW-1:0] left_o, right_o;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  zc_volume #(.DATA_W(DW), .VOL_W(5), .TIMEOUT(TO)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid),
    .left_i(left), .right_i(right), .vol_i(vol),
    .mute_i(mute), .zc_en_i(zc),
    .valid_o(valid_o), .left_o(left_o), .right_o(right_o), .muted_o(muted_o)
  );

  function automatic int scale(input int x, input int code);
    longint g = 32768;
    for (int i = 0; i < code; i++) g = (g * 26029 + 16384) >>> 15;
    return int'((longint'(x) * g + 16384) >>> 15);
  endfunction

  function automatic string tag_of(input int i);
    if (i <= 3 || i == 22) return "R5 R3";
    if (i <= 6)            return "R6 R7";
    if (i <= 9)            return "R9";
    return "R8";
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic [4:0] v, input logic m, input logic z,
                       input logic signed [DW-1:0] l, input logic signed [DW-1:0] r);
    @(negedge clk);
    vol = v; mute = m; zc = z; left = l; right = r; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    int hl, hr;
    repeat (3) @(negedge clk);
    chk("R1 muted", int'(muted_o), 1);
    chk("R1 left", int'(left_o), 0);
    chk("R1 valid", int'(valid_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 hold after release", int'(muted_o), 1);

    for (int i = 0; i < NV; i++) begin
      vec_t v = VECS[i];
      int el, er;
      apply(v.vol, v.mute, v.zc, v.l, v.r);
      el = v.eml ? 0 : scale(int'(v.l), int'(v.vol));
      er = v.emr ? 0 : scale(int'(v.r), int'(v.vol));
      chk({tag_of(i), v.eml ? " R10" : "", " left"}, int'(left_o), el);
      chk({tag_of(i), v.emr ? " R10" : "", " right"}, int'(right_o), er);
      chk("R7 muted flag", int'(muted_o), int'(v.eml | v.emr));
      chk("R2 valid_o", int'(valid_o), 1);
      hl = int'(left_o); hr = int'(right_o);
      // idle cycle with junk on inputs: nothing may change
      mute = ~mute; zc = ~zc; left = 16'sd12345; vol = 5'd7;
      @(negedge clk);
      chk("R2 idle valid_o", int'(valid_o), 0);
      chk("R2 idle left", int'(left_o), hl);
      chk("R2 idle right", int'(right_o), hr);
      chk("R2 idle flag", int'(muted_o), int'(v.eml | v.emr));
    end

    // full sweep of codes at both full-scale extremes, ungated
    for (int c = 0; c < 32; c++) begin
      apply(5'(c), 1'b0, 1'b0, 16'sd32767, -16'sd32768);
      chk("R3 R4 sweep pos", int'(left_o), scale(32767, c));
      chk("R3 R4 sweep neg", int'(right_o), scale(-32768, c));
    end
    apply(5'd0, 1'b0, 1'b0, -16'sd7, 16'sd9);
    chk("R3 unity left", int'(left_o), -7);
    chk("R3 unity right", int'(right_o), 9);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule